// File: doc/BRIEF.md
# Relative Branch-and-Link Unit

This block handles the long PC-relative call of a 16-bit-word instruction set. Each cycle it may be offered a 32-bit instruction word, made of two 16-bit words, together with the byte address of that word. If the word is a branch-and-link, the block computes the call target and the return address. It then raises a PC redirect strobe and a link-register write strobe together.

The displacement field counts halfwords. It is doubled into a byte offset, sign-extended, and added to the address of the branch itself, not to the following instruction. The address of the following instruction (branch address plus 4) is the value written to the link register. The branch is unconditional, so a recognised call always ends sequential fetch. All arithmetic wraps modulo 2^32. By default the results are registered, one cycle after the word is offered.

Top module: `bal_unit`

## Requirements
- R1: While rst_ni is low, and until the first accepted word after reset, redirect_o and link_we_o are 0, and target_o and link_data_o are 0.
- R2: A word is accepted only when valid_i is 1 and instr_i[31:24] equals 8'hC0. In the cycle after any other input, both strobes are 0.
- R3: For an accepted word, target_o equals pc_i + sext(2 * instr_i[23:1]). Here instr_i[23] is the sign bit of the 23-bit halfword displacement, so the byte offset is a 24-bit signed value.
- R4: For an accepted word, link_data_o equals pc_i + 4.
- R5: redirect_o and link_we_o are always equal. Both are 1 for exactly the one cycle after each accepted word. Back-to-back accepted words give back-to-back strobes, each with its own results.
- R6: Target and link sums wrap modulo 2^32. For example, pc_i = 32'hFFFF_FFFC gives link_data_o = 0.
- R7: instr_i[0] has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | instr_i and pc_i are meaningful this cycle |
| instr_i | input | 32 | Instruction word, first halfword in bits 31:16 |
| pc_i | input | 32 | Byte address of the instruction |
| redirect_o | output | 1 | Fetch must restart at target_o |
| target_o | output | 32 | Call target address |
| link_we_o | output | 1 | Write link_data_o to the link register |
| link_data_o | output | 32 | Return address |

## Verification
A wrong opcode decode or a stuck output register shows up one cycle after the offending word, as a strobe that appears or goes missing. A fault in sign handling or offset scaling shows up only on calls with that displacement sign or magnitude. For this reason the stimulus covers both extreme displacements, zero, and both signs. An adder that adds to the wrong base, such as the next PC, shifts every target by 4 on the first call. Wrap faults appear only near the top of the address space, so addresses close to 2^32 are applied on purpose.

// File: rtl/bal_pkg.sv
package bal_pkg;
  localparam int unsigned ADDR_W    = 32;
  localparam int unsigned INSTR_W   = 32;
  localparam int unsigned OPC_W     = 8;
  localparam logic [7:0]  OPC_CALL  = 8'hC0;
  localparam int unsigned DISP_W    = 23;
  localparam int unsigned INSTR_LEN = 4;

  typedef struct packed {
    logic              fire;
    logic [ADDR_W-1:0] target;
    logic [ADDR_W-1:0] link;
  } bal_res_t;
endpackage

// File: rtl/bal_decode.sv
module bal_decode #(
  parameter int unsigned OPC_W = 8,
  parameter logic [OPC_W-1:0] OPC_VAL = '0
) (
  input  logic             valid_i,
  input  logic [OPC_W-1:0] opc_i,
  output logic             hit_o
);
  assign hit_o = valid_i && (opc_i == OPC_VAL);
endmodule

// File: rtl/bal_target_calc.sv
module bal_target_calc #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DISP_W = 23
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic [ADDR_W-1:0] target_o
);
  localparam int unsigned OFFS_W = DISP_W + 1;

  logic [OFFS_W-1:0] offs_bytes;
  logic [ADDR_W-1:0] offs_ext;

  // halfword count -> byte offset, sign bit is the field msb
  assign offs_bytes = {disp_i, 1'b0};

  generate
    if (ADDR_W > OFFS_W) begin : g_ext
      assign offs_ext = {{(ADDR_W-OFFS_W){offs_bytes[OFFS_W-1]}}, offs_bytes};
    end else begin : g_trunc
      assign offs_ext = offs_bytes[ADDR_W-1:0];
    end
  endgenerate

  assign target_o = pc_i + offs_ext;
endmodule

// File: rtl/bal_link_calc.sv
module bal_link_calc #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned INSTR_LEN = 4
) (
  input  logic [ADDR_W-1:0] pc_i,
  output logic [ADDR_W-1:0] link_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSTR_LEN);
  assign link_o = pc_i + STEP;
endmodule

// File: rtl/bal_out_stage.sv
module bal_out_stage #(
  parameter int unsigned ADDR_W = 32,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic [ADDR_W-1:0] target_i,
  input  logic [ADDR_W-1:0] link_i,
  output logic              fire_o,
  output logic [ADDR_W-1:0] target_o,
  output logic [ADDR_W-1:0] link_o
);
  generate
    if (REG_OUT) begin : g_reg
      logic              fire_q;
      logic [ADDR_W-1:0] target_q;
      logic [ADDR_W-1:0] link_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          fire_q <= 1'b0;
        end else begin
          fire_q <= fire_i;
        end
      end

      // data only loads on a hit; holds otherwise
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          target_q <= '0;
          link_q   <= '0;
        end else if (fire_i) begin
          target_q <= target_i;
          link_q   <= link_i;
        end
      end

      assign fire_o   = fire_q;
      assign target_o = target_q;
      assign link_o   = link_q;
    end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk_i ^ rst_ni;
      assign fire_o   = fire_i;
      assign target_o = target_i;
      assign link_o   = link_i;
    end
  endgenerate
endmodule

// File: rtl/bal_unit.sv
module bal_unit
  import bal_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [ADDR_W-1:0]  pc_i,
  output logic               redirect_o,
  output logic [ADDR_W-1:0]  target_o,
  output logic               link_we_o,
  output logic [ADDR_W-1:0]  link_data_o
);
  localparam int unsigned OPC_LSB = INSTR_W - OPC_W;

  bal_res_t comb_res;
  bal_res_t out_res;
  logic     unused_lsb;

  assign unused_lsb = instr_i[0];

  bal_decode #(
    .OPC_W   (OPC_W),
    .OPC_VAL (OPC_CALL)
  ) decode_i (
    .valid_i (valid_i),
    .opc_i   (instr_i[INSTR_W-1:OPC_LSB]),
    .hit_o   (comb_res.fire)
  );

  bal_target_calc #(
    .ADDR_W (ADDR_W),
    .DISP_W (DISP_W)
  ) target_i (
    .pc_i     (pc_i),
    .disp_i   (instr_i[DISP_W:1]),
    .target_o (comb_res.target)
  );

  bal_link_calc #(
    .ADDR_W    (ADDR_W),
    .INSTR_LEN (INSTR_LEN)
  ) link_i (
    .pc_i   (pc_i),
    .link_o (comb_res.link)
  );

  bal_out_stage #(
    .ADDR_W  (ADDR_W),
    .REG_OUT (REG_OUT)
  ) out_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fire_i   (comb_res.fire),
    .target_i (comb_res.target),
    .link_i   (comb_res.link),
    .fire_o   (out_res.fire),
    .target_o (out_res.target),
    .link_o   (out_res.link)
  );

  assign redirect_o  = out_res.fire;
  assign link_we_o   = out_res.fire;
  assign target_o    = out_res.target;
  assign link_data_o = out_res.link;
endmodule

// File: rtl/bal_unit_chk.sv
module bal_unit_chk #(
  parameter bit REG_OUT = 1'b1
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic [31:0] instr_i,
  input logic [31:0] pc_i,
  input logic        redirect_o,
  input logic [31:0] target_o,
  input logic        link_we_o,
  input logic [31:0] link_data_o
);
  logic [31:0] offs_c;
  logic        hit_c;
  assign offs_c = {{8{instr_i[23]}}, instr_i[23:1], 1'b0};
  assign hit_c  = valid_i && (instr_i[31:24] == 8'hC0);

  // R5
  strobe_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o == link_we_o);

  generate
    if (REG_OUT) begin : g_seq
      // R2
      no_false_redirect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !hit_c |=> !redirect_o);
      // R5
      redirect_on_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit_c |=> redirect_o);
      // R3
      target_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit_c |=> target_o == $past(pc_i + offs_c));
      // R4
      link_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit_c |=> link_data_o == $past(pc_i) + 32'd4);
    end else begin : g_comb
      // R2
      no_false_redirect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        redirect_o == hit_c);
      // R3
      target_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        redirect_o |-> target_o == pc_i + offs_c);
      // R4
      link_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        redirect_o |-> link_data_o == pc_i + 32'd4);
    end
  endgenerate
endmodule

bind bal_unit bal_unit_chk #(.REG_OUT(REG_OUT)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .instr_i     (instr_i),
  .pc_i        (pc_i),
  .redirect_o  (redirect_o),
  .target_o    (target_o),
  .link_we_o   (link_we_o),
  .link_data_o (link_data_o)
);

// File: tb/bal_unit_tb_top.sv
module bal_unit_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] pc = '0;
  logic        redirect, link_we;
  logic [31:0] target, link_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model state
  bit          exp_fire = 1'b0;
  logic [31:0] exp_target = '0;
  logic [31:0] exp_link = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bal_unit dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .valid_i     (valid),
    .instr_i     (instr),
    .pc_i        (pc),
    .redirect_o  (redirect),
    .target_o    (target),
    .link_we_o   (link_we),
    .link_data_o (link_data)
  );

  function automatic longint disp_bytes(input logic [31:0] w);
    longint f = longint'((w >> 1) & 32'h007F_FFFF);
    if (f >= 64'd4194304) f = f - 64'd8388608;
    return f * 2;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_fire   <= 1'b0;
      exp_target <= '0;
      exp_link   <= '0;
    end else begin
      exp_fire <= valid && (instr[31:24] == 8'hC0);
      if (valid && (instr[31:24] == 8'hC0)) begin
        exp_target <= 32'((longint'(pc) + disp_bytes(instr)) & 64'hFFFF_FFFF);
        exp_link   <= 32'((longint'(pc) + 4) & 64'hFFFF_FFFF);
      end
    end
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // compare every cycle, away from the rising edge
  always @(negedge clk) begin
    if (!done) begin
      check("R2", "redirect", {31'd0, redirect}, {31'd0, exp_fire});
      check("R5", "link_we", {31'd0, link_we}, {31'd0, exp_fire});
      if (exp_fire || !rst_n) begin
        check("R3", "target", target, exp_target);
        check("R4", "link_data", link_data, exp_link);
      end
    end
  end

  task automatic drive(input bit v, input logic [31:0] w, input logic [31:0] a);
    @(negedge clk);
    valid = v;
    instr = w;
    pc    = a;
  endtask

  task automatic call_and_check(input string req, input logic [31:0] w,
                                input logic [31:0] a,
                                input logic [31:0] t, input logic [31:0] l);
    drive(1'b1, w, a);
    @(negedge clk);
    valid = 1'b0;
    check(req, "directed target", target, t);
    check(req, "directed link", link_data, l);
    check(req, "directed strobe", {31'd0, redirect}, 32'd1);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", "reset redirect", {31'd0, redirect}, 32'd0);
    check("R1", "reset target", target, 32'd0);
    check("R1", "reset link", link_data, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "post-reset link_we", {31'd0, link_we}, 32'd0);

    // R3: positive, negative, extremes, zero
    call_and_check("R3", 32'hC000_0010, 32'h0000_1000, 32'h0000_1010, 32'h0000_1004);
    call_and_check("R3", 32'hC0FF_FFFE, 32'h0000_1000, 32'h0000_0FFE, 32'h0000_1004);
    call_and_check("R3", 32'hC07F_FFFE, 32'h1000_0000, 32'h107F_FFFE, 32'h1000_0004);
    call_and_check("R3", 32'hC080_0000, 32'h1000_0000, 32'h0F80_0000, 32'h1000_0004);
    call_and_check("R4", 32'hC000_0000, 32'h0000_2468, 32'h0000_2468, 32'h0000_246C);
    // R6: wrap
    call_and_check("R6", 32'hC000_0008, 32'hFFFF_FFFC, 32'h0000_0004, 32'h0000_0000);
    call_and_check("R6", 32'hC0FF_FFF0, 32'h0000_0004, 32'hFFFF_FFF4, 32'h0000_0008);
    // R7: lsb ignored
    call_and_check("R7", 32'hC000_0011, 32'h0000_1000, 32'h0000_1010, 32'h0000_1004);

    // R2: non-matching opcodes and valid low
    drive(1'b1, 32'hC100_0010, 32'h0000_3000);
    drive(1'b1, 32'h4000_0010, 32'h0000_3000);
    drive(1'b0, 32'hC000_0010, 32'h0000_3000);
    drive(1'b1, 32'h0000_0000, 32'h0000_3000);
    @(negedge clk);
    check("R2", "no strobe after valid low", {31'd0, redirect}, 32'd0);

    // R5: back-to-back calls
    drive(1'b1, 32'hC000_0004, 32'h0000_0100);
    drive(1'b1, 32'hC000_0008, 32'h0000_0200);
    drive(1'b0, 32'h0, 32'h0);

    // mixed stimulus, model compared every cycle
    for (int i = 0; i < 400; i++) begin
      logic [31:0] w = $urandom;
      if ($urandom_range(0, 1) == 1) w[31:24] = 8'hC0;
      drive(1'($urandom_range(0, 3) != 0), w, $urandom);
    end
    drive(1'b0, 32'h0, 32'h0);
    @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule